// File: doc/BRIEF.md
# SPI Port with Configurable Underrun and Overrun Policies

This block is a byte-wide SPI port that can run as bus master or as a selected slave. It uses clock mode 0: the clock idles low, data changes after a falling edge and is sampled on a rising edge. Words go out most significant bit first. One transmit word and one receive word are buffered between the host and the shift register. Two control bits set what the port does when software falls behind. One picks what a new word carries when no fresh transmit word is waiting. The other picks whether a word that arrives while the receive buffer still holds an unread word replaces it or is dropped.

The port can also hand over bus mastership. A port set up as master that sees its select input pulled low releases the clock and data drivers in the same cycle. It then clears its own master bit, records a sticky fault flag and carries on as a slave. The data pins are open drain. The block only asserts an enable, and only while it pulls a line low. A released line reads high through the board pull-up.

The host side is a plain register port: a 2-bit address, a write strobe and a read strobe. Read data is combinational on the address. The port takes no back-pressure. A host write or read is always accepted in the cycle it is strobed, and the status flags tell software whether a buffer is free or holds data.

Top module: `spi_bufport`

## Requirements
- R1: After reset the control register reads 0x00, the status register reads 0x01 (transmit empty) and all of sck_oe, mosi_oe and miso_oe are 0.
- R2: Register map at host_addr: 0 = control, 1 = transmit data (write only), 2 = receive data, 3 = status. The control register holds bit0 = master, bit1 = send zeros, bit2 = overwrite, bit3 = spare (read back), bits 7:4 = divider field D. The status register holds bit0 = transmit empty, bit1 = receive full, bit2 = overrun, bit3 = mode fault.
- R3: Writing the transmit register clears transmit empty. The buffered word moves to the shift register, and transmit empty sets again, when the next word starts. A host_rd at address 2 clears receive full.
- R4: As master with a word buffered, the port drives sck high and low with a period of 2*(D+1) clock cycles for 8 rising edges, then leaves sck low. The MOSI line shows the word MSB first and changes only while sck is low. The bits sampled from miso_in on the rising edges land in the receive buffer and set receive full.
- R5: As a slave while ss_n_in is low, the port samples mosi_in on rising edges of sck_in. It presents its outgoing word on MISO MSB first, with the first bit valid before the first rising edge and each later bit updated after a falling edge.
- R6: With send zeros = 1 and no word buffered, a new word goes out as 0x00.
- R7: With send zeros = 0 and no word buffered, a new word repeats the last word taken from the transmit buffer.
- R8: With overwrite = 1, a word received while receive full is set replaces the stored word.
- R9: With overwrite = 0, a word received while receive full is set is dropped, and the stored word is kept.
- R10: Overrun sets when a word arrives while receive full is set, under either policy. It stays set until 1 is written to status bit2.
- R11: While master, ss_n_in low forces sck_oe and mosi_oe to 0 in the same cycle. Within a few cycles the master bit reads 0 and mode fault sets. Mode fault clears only when 1 is written to status bit3.
- R12: Open drain: mosi_oe and miso_oe are 1 only while the port pulls its line low, meaning it is sending a 0 bit. miso_oe is 0 whenever ss_n_in is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | 2 | Register select |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | WORD_W | Write data |
| host_rd | input | 1 | Read strobe (side effect at address 2) |
| host_rdata | output | WORD_W | Read data for host_addr, combinational |
| sck_in | input | 1 | SPI clock as seen on the bus |
| sck_out | output | 1 | SPI clock driven when master |
| sck_oe | output | 1 | Clock driver enable |
| ss_n_in | input | 1 | Device select, active low |
| mosi_in | input | 1 | MOSI line as seen on the bus |
| mosi_oe | output | 1 | Pull MOSI low |
| miso_in | input | 1 | MISO line as seen on the bus |
| miso_oe | output | 1 | Pull MISO low |

## Verification
The bench runs back-to-back slave words with the transmit buffer left empty, under both underrun choices. A design that got this wrong would send stale data instead of zeros, or send zeros instead of the previous word. It also fills the receive buffer under both overrun choices and checks the stored word and the sticky flag. A wrong design would overwrite when it should keep the word, keep it when it should overwrite, or raise overrun under only one policy. In master mode it checks clock period, bit order and when MOSI changes against a loopback, so a swapped bit order or data moving while sck is high shows up. The bench also pulls select low in the middle of a master word. A design that waits for its synchronizer or for the end of the word would still be driving the clock or MOSI in that cycle.

// File: rtl/spi_bufport_pkg.sv
package spi_bufport_pkg;
  localparam int DIV_W = 4;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_TX   = 2'd1;
  localparam logic [1:0] A_RX   = 2'd2;
  localparam logic [1:0] A_STAT = 2'd3;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic             spare;
    logic             overwrite;
    logic             send_zeros;
    logic             master;
  } ctrl_t;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int          W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/spi_clkgen.sv
module spi_clkgen #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             sck,
  output logic             rise,
  output logic             fall
);
  logic [DIV_W-1:0] cnt;
  logic             tick;

  assign tick = run && (cnt == div);
  assign rise = tick && !sck;
  assign fall = tick && sck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sck <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      sck <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      sck <= !sck;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic [WORD_W-1:0] load_word,
  input  logic              rise,
  input  logic              fall,
  input  logic              sample_bit,
  output logic              busy,
  output logic              out_bit,
  output logic              word_done,
  output logic [WORD_W-1:0] rx_word
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

  logic [WORD_W-1:0] tx_sh;
  logic [WORD_W-2:0] rx_sh;
  logic [CNT_W-1:0]  cnt;

  assign out_bit   = tx_sh[WORD_W-1];
  assign word_done = busy && rise && (cnt == LAST);
  assign rx_word   = {rx_sh, sample_bit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh <= '1;
      rx_sh <= '0;
      cnt   <= '0;
      busy  <= 1'b0;
    end else if (abort) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else if (start) begin
      tx_sh <= load_word;
      cnt   <= '0;
      busy  <= 1'b1;
    end else if (busy) begin
      if (rise) begin
        rx_sh <= {rx_sh[WORD_W-3:0], sample_bit};
        cnt   <= cnt + 1'b1;
      end else if (fall && cnt != '0) begin
        if (cnt == FULL) busy <= 1'b0;
        else             tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/spi_bufport.sv
module spi_bufport
  import spi_bufport_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        host_addr,
  input  logic              host_wr,
  input  logic [WORD_W-1:0] host_wdata,
  input  logic              host_rd,
  output logic [WORD_W-1:0] host_rdata,
  input  logic              sck_in,
  output logic              sck_out,
  output logic              sck_oe,
  input  logic              ss_n_in,
  input  logic              mosi_in,
  output logic              mosi_oe,
  input  logic              miso_in,
  output logic              miso_oe
);
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t             ctrl_q;
  logic [WORD_W-1:0] tx_buf, last_word, rx_buf, rx_word, load_word;
  logic              tx_full, rx_full, overrun, mode_fault;
  logic              s_sck, s_ss_n, s_mosi, sck_d;
  logic              m_rise, m_fall, s_rise, s_fall, rise, fall;
  logic              busy, out_bit, word_done, sample_bit;
  logic              fault, m_start, s_start, start, abort;
  logic              overwrite_en, master_en;
  logic              wr_ctrl, wr_tx, wr_stat, rd_rx;

  assign master_en    = ctrl_q.master;
  assign overwrite_en = ctrl_q.overwrite;
  assign wr_ctrl = host_wr && host_addr == A_CTRL;
  assign wr_tx   = host_wr && host_addr == A_TX;
  assign wr_stat = host_wr && host_addr == A_STAT;
  assign rd_rx   = host_rd && host_addr == A_RX;

  spi_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({sck_in, ss_n_in, mosi_in}),
    .q({s_sck, s_ss_n, s_mosi})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_d <= 1'b0;
    else        sck_d <= s_sck;
  end

  assign s_rise = s_sck && !sck_d;
  assign s_fall = !s_sck && sck_d;

  spi_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk(clk), .rst_n(rst_n),
    .run(master_en && busy), .div(ctrl_q.div),
    .sck(sck_out), .rise(m_rise), .fall(m_fall)
  );

  assign rise       = master_en ? m_rise  : s_rise;
  assign fall       = master_en ? m_fall  : s_fall;
  assign sample_bit = master_en ? miso_in : s_mosi;

  assign fault   = master_en && !s_ss_n;
  assign m_start = master_en && s_ss_n && tx_full && !busy;
  assign s_start = !master_en && !s_ss_n && !busy;
  assign start   = m_start || s_start;
  assign abort   = fault || (!master_en && s_ss_n && busy);

  assign load_word = tx_full           ? tx_buf :
                     ctrl_q.send_zeros ? '0     : last_word;

  spi_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .start(start), .abort(abort), .load_word(load_word),
    .rise(rise), .fall(fall), .sample_bit(sample_bit),
    .busy(busy), .out_bit(out_bit),
    .word_done(word_done), .rx_word(rx_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      tx_buf     <= '0;
      tx_full    <= 1'b0;
      last_word  <= '0;
      rx_buf     <= '0;
      rx_full    <= 1'b0;
      overrun    <= 1'b0;
      mode_fault <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(host_wdata[CTRL_W-1:0]);
      if (fault) begin
        ctrl_q.master <= 1'b0;
        mode_fault    <= 1'b1;
      end else if (wr_stat && host_wdata[3]) begin
        mode_fault <= 1'b0;
      end

      if (wr_tx) begin
        tx_buf  <= host_wdata;
        tx_full <= 1'b1;
      end else if (start && tx_full) begin
        tx_full   <= 1'b0;
        last_word <= tx_buf;
      end

      if (word_done) begin
        if (!rx_full || ctrl_q.overwrite) rx_buf <= rx_word;
        rx_full <= 1'b1;
        if (rx_full) overrun <= 1'b1;
        else if (wr_stat && host_wdata[2]) overrun <= 1'b0;
      end else begin
        if (rd_rx) rx_full <= 1'b0;
        if (wr_stat && host_wdata[2]) overrun <= 1'b0;
      end
    end
  end

  always_comb begin
    case (host_addr)
      A_CTRL:  host_rdata = WORD_W'(ctrl_q);
      A_RX:    host_rdata = rx_buf;
      A_STAT:  host_rdata = WORD_W'({mode_fault, overrun, rx_full, !tx_full});
      default: host_rdata = '0;
    endcase
  end

  assign sck_oe  = master_en && ss_n_in;
  assign mosi_oe = master_en && ss_n_in && busy && !out_bit;
  assign miso_oe = !master_en && !ss_n_in && !s_ss_n && busy && !out_bit;
endmodule

// File: rtl/spi_bufport_chk.sv
module spi_bufport_chk #(
  parameter int WORD_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ss_n_in,
  input logic              sck_oe,
  input logic              mosi_oe,
  input logic              miso_oe,
  input logic              word_done,
  input logic              rx_full,
  input logic              overwrite_en,
  input logic              overrun,
  input logic              mode_fault,
  input logic              master_en,
  input logic [WORD_W-1:0] rx_buf
);
  p_release_on_select_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !ss_n_in |-> (!sck_oe && !mosi_oe));

  p_miso_only_selected_r12: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe |-> !ss_n_in);

  p_discard_keeps_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && rx_full && !overwrite_en) |=> $stable(rx_buf));

  p_overrun_flagged_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && rx_full) |=> overrun);

  p_fault_drops_master_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_fault) |-> !master_en);
endmodule

bind spi_bufport spi_bufport_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ss_n_in(ss_n_in),
  .sck_oe(sck_oe), .mosi_oe(mosi_oe), .miso_oe(miso_oe),
  .word_done(word_done), .rx_full(rx_full), .overwrite_en(overwrite_en),
  .overrun(overrun), .mode_fault(mode_fault), .master_en(master_en),
  .rx_buf(rx_buf)
);

// File: tb/spi_bufport_tb.sv
module spi_bufport_tb;
  localparam int HALF = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] host_addr = '0;
  logic       host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_wdata = '0, host_rdata;
  logic       sck_out, sck_oe, mosi_oe, miso_oe;
  logic       tb_sck = 1'b0, tb_ss_n = 1'b1, tb_mosi = 1'b1, loop = 1'b0;
  wire        sck_line  = sck_oe ? sck_out : tb_sck;
  wire        mosi_line = !mosi_oe && tb_mosi;
  wire        miso_line = !miso_oe && (loop ? mosi_line : 1'b1);

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  spi_bufport u_dut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
    .sck_in(sck_line), .sck_out(sck_out), .sck_oe(sck_oe), .ss_n_in(tb_ss_n),
    .mosi_in(mosi_line), .mosi_oe(mosi_oe), .miso_in(miso_line), .miso_oe(miso_oe)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input bit pop, output logic [7:0] d);
    @(negedge clk); host_addr = a; host_rd = pop; #1 d = host_rdata;
    @(negedge clk); host_rd = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic slave_xfer(input logic [7:0] mo, output logic [7:0] mi);
    tb_ss_n = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      tb_mosi = mo[i];
      wait_cyc(HALF);
      mi[i] = miso_line;
      tb_sck = 1'b1;
      wait_cyc(HALF);
      tb_sck = 1'b0;
    end
    wait_cyc(HALF);
    tb_ss_n = 1'b1;
    tb_mosi = 1'b1;
    wait_cyc(HALF);
  endtask

  typedef struct packed {
    logic [7:0] ctrl;
    logic       do_wr;
    logic [7:0] tx;
    logic [7:0] mosi;
    logic       do_rd;
    logic [7:0] exp_miso;
    logic [7:0] exp_rx;
    logic [7:0] exp_st;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{8'h00, 1'b1, 8'h3C, 8'h81, 1'b1, 8'h3C, 8'h81, 8'h03},
    '{8'h00, 1'b0, 8'h00, 8'h42, 1'b0, 8'h3C, 8'h42, 8'h03},
    '{8'h00, 1'b0, 8'h00, 8'h99, 1'b1, 8'h3C, 8'h42, 8'h07},
    '{8'h02, 1'b0, 8'h00, 8'h5A, 1'b0, 8'h00, 8'h5A, 8'h07},
    '{8'h06, 1'b1, 8'hC3, 8'hE7, 1'b1, 8'hC3, 8'hE7, 8'h07},
    '{8'h04, 1'b0, 8'h00, 8'h18, 1'b1, 8'hC3, 8'h18, 8'h07}
  };

  logic       mon_en = 1'b0;
  logic [7:0] cap = '0;
  int         cyc = 0, last_rise = 0, period = 0, nrise = 0, bad_mosi = 0;
  logic       prev_sck = 1'b0, prev_mosi = 1'b1;

  always @(negedge clk) begin
    cyc++;
    if (mon_en) begin
      if (sck_line && !prev_sck) begin
        cap = {cap[6:0], mosi_line};
        if (nrise > 0) period = cyc - last_rise;
        last_rise = cyc;
        nrise++;
      end
      if (mosi_line != prev_mosi && sck_line) bad_mosi++;
    end
    prev_sck  = sck_line;
    prev_mosi = mosi_line;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, mi;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);

    // R1 reset state
    rd(2'd0, 0, d); check("R1 ctrl", d, 8'h00);
    rd(2'd3, 0, d); check("R1 status", d, 8'h01);
    check("R1 oe", {sck_oe, mosi_oe, miso_oe}, 3'b000);
    wr(2'd0, 8'h08); rd(2'd0, 0, d); check("R2 spare bit readback", d, 8'h08);

    // Slave vector table: R3 R5 R6 R7 R8 R9 R10
    foreach (VECS[k]) begin
      wr(2'd0, VECS[k].ctrl);
      if (VECS[k].do_wr) begin
        wr(2'd1, VECS[k].tx);
        rd(2'd3, 0, d); check($sformatf("R3 tx_empty clear v%0d", k), d[0], 1'b0);
      end
      slave_xfer(VECS[k].mosi, mi);
      check($sformatf("R5/R6/R7 miso v%0d", k), mi, VECS[k].exp_miso);
      rd(2'd3, 0, d); check($sformatf("R10 status v%0d", k), d, VECS[k].exp_st);
      rd(2'd2, 0, d); check($sformatf("R8/R9 rx v%0d", k), d, VECS[k].exp_rx);
      if (VECS[k].do_rd) begin
        rd(2'd2, 1, d);
        rd(2'd3, 0, d); check($sformatf("R3 rx_full clear v%0d", k), d[1], 1'b0);
      end
    end

    // R10 overrun sticky, write 0 keeps, write 1 clears
    wr(2'd3, 8'h00); rd(2'd3, 0, d); check("R10 overrun kept", d, 8'h05);
    wr(2'd3, 8'h04); rd(2'd3, 0, d); check("R10 overrun cleared", d, 8'h01);
    // R12 idle slave releases MISO
    check("R12 miso released unselected", miso_oe, 1'b0);

    // R4 master transfer with loopback, D=1 -> period 4
    loop = 1'b1; mon_en = 1'b1;
    wr(2'd0, 8'h11);
    wr(2'd1, 8'hA5);
    wait_cyc(80);
    mon_en = 1'b0;
    check("R4 bits on mosi", cap, 8'hA5);
    check("R4 rise count", nrise, 8);
    check("R4 sck period", period, 4);
    check("R4 mosi stable while sck high", bad_mosi, 0);
    check("R4 sck idle low", {sck_oe, sck_line}, 2'b10);
    rd(2'd2, 1, d); check("R4 rx loopback", d, 8'hA5);
    rd(2'd3, 0, d); check("R4 status after read", d, 8'h01);
    loop = 1'b0;

    // R11 mode fault mid word, D=7
    wr(2'd0, 8'h71);
    wr(2'd1, 8'h00);
    wait_cyc(20);
    check("R12 mosi pulled low for 0 bit", mosi_oe, 1'b1);
    @(negedge clk); tb_ss_n = 1'b0; #1;
    check("R11 release same cycle", {sck_oe, mosi_oe}, 2'b00);
    wait_cyc(6);
    rd(2'd3, 0, d); check("R11 status fault", d, 8'h09);
    rd(2'd0, 0, d); check("R11 master bit cleared", d, 8'h70);
    check("R12 slave drives low for repeated 0", miso_oe, 1'b1);
    wr(2'd3, 8'h00); rd(2'd3, 0, d); check("R11 fault sticky", d[3], 1'b1);
    wr(2'd3, 8'h08); rd(2'd3, 0, d); check("R11 fault cleared", d[3], 1'b0);
    tb_ss_n = 1'b1;
    wait_cyc(4);
    check("R12 miso released after deselect", miso_oe, 1'b0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule